// File: doc/BRIEF.md
# Serial ADC Output Port Model

This block models the device side of a serial analog-to-digital converter port. A host controller under test drives the chip select `cs_n_i` and the serial clock `sclk_i`. The model answers on `sdo_o`. The conversion itself is not modelled. When a frame opens, the block latches a parallel sample word from `sample_i`. It then shifts that word out MSB first on rising serial clock edges, but only after the first falling edge of the frame has been seen.

The block counts the falling serial-clock edges in each frame, and that count selects what the frame does:
- A long enough frame moves the model into acquisition.
- A frame that closes too early marks the result of the next frame as invalid.
- A frame of exactly the calibration length moves the model into a timed offset-calibration state. The calibration length is one value while the power-up condition holds and another value afterwards.

When calibration ends, the block raises a done flag and clears the power-up condition.

The pins are sampled on the system clock `clk`, which must be several times faster than `sclk_i`. A pin change takes effect on the outputs at the second rising edge of `clk` after the change. A host model or bench can read the state, the invalid marker and the done flag directly.

Top module: `adc_sport_model`

## Requirements
- R1: After reset, `state_o` is 0 (idle), and `sdo_o`, `data_invalid_o` and `cal_done_o` are all 0. The power-up condition is set.
- R2: `sdo_o` is 0 in the cycle after a falling edge of `cs_n_i` is seen, and it stays 0 for as long as `cs_n_i` is high.
- R3: On a falling edge of `cs_n_i`, `sample_i` is captured. The first rising `sclk_i` edge after the frame's first falling edge drives the captured MSB on `sdo_o`. Each later rising edge drives the next lower bit.
- R4: Once all SAMPLE_W bits have been sent, every further rising `sclk_i` edge in the frame drives 0.
- R5: A rising `sclk_i` edge seen before any falling edge of the frame drives 0 and consumes no data bit.
- R6: The falling `sclk_i` edge that brings the frame count to ACQ_EDGES (default 18) sets `state_o` to 2 (acquisition), unless the state is 3. A frame in progress shows `state_o` = 1. A frame that closes while still at state 1 returns the state to 0.
- R7: A frame that closes with fewer than ACQ_EDGES falling edges causes `data_invalid_o` to be 1 throughout the next frame. A frame with at least ACQ_EDGES falling edges clears the mark for the frame that follows. `data_invalid_o` keeps its value between frames.
- R8: While the power-up condition holds, a frame closing with exactly PWRUP_CAL_EDGES (default 24) falling edges sets `state_o` to 3 (calibration). A 64-edge frame does not.
- R9: Once the power-up condition is cleared, a frame closing with exactly NORM_CAL_EDGES (default 64) falling edges enters state 3. A 24-edge frame does not.
- R10: State 3 lasts exactly CAL_CYCLES clock cycles. The state then becomes 2, `cal_done_o` rises, and the power-up condition clears. `cal_done_o` is 0 whenever the state is 3.
- R11: A frame that opens, counts or closes while the state is 3 cannot re-enter or leave calibration. This includes a frame that closes in the cycle the timer expires: that cycle ends in state 2 with `cal_done_o` set.
- R12: A change on `cs_n_i` or `sclk_i` is acted on at the second rising edge of `clk` after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host, idle high |
| sample_i | input | SAMPLE_W | Parallel sample captured when a frame opens |
| sdo_o | output | 1 | Serial data to the host |
| state_o | output | 2 | 0 idle, 1 frame in progress, 2 acquisition, 3 calibration |
| data_invalid_o | output | 1 | The current or last frame carries an invalid result |
| cal_done_o | output | 1 | Offset calibration has completed |

## Verification
Two events can fall in the same cycle: the calibration timer expiring, and a frame closing with exactly the calibration edge count. The bench provokes this by running a full 64-edge frame inside a calibration window. It times the chip-select release so that the release is acted on in the expiry cycle. That cycle must end in acquisition with the done flag set and no new calibration. A behavioural model in the bench, driven by a queue of past pin samples, predicts every output on every clock. Directed checks separately pin the exact cycles of the calibration length and of the pin latency.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ACQ   = 2'd2,
    ST_CAL   = 2'd3
  } sport_state_e;

  // Calibration length depends on whether the power-up condition is pending.
  function automatic logic calib_match(input logic pwr_pending,
                                       input int unsigned edges,
                                       input int unsigned pwrup_len,
                                       input int unsigned normal_len);
    return pwr_pending ? (edges == pwrup_len) : (edges == normal_len);
  endfunction

  // A frame is short when it closes before the acquisition edge count.
  function automatic logic frame_short(input int unsigned edges,
                                       input int unsigned need);
    return edges < need;
  endfunction

endpackage

// File: rtl/adc_sport_edge.sv
// Samples asynchronous pins on clk and flags their edges one cycle later.
module adc_sport_edge #(
  parameter int unsigned W        = 2,
  parameter logic [W-1:0] IDLE_LVL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] now_q;
  logic [W-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= IDLE_LVL;
      old_q <= IDLE_LVL;
    end else begin
      now_q <= pin_i;
      old_q <= now_q;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign lvl_o[g]  = now_q[g];
    assign rise_o[g] = now_q[g] & ~old_q[g];
    assign fall_o[g] = ~now_q[g] & old_q[g];
  end

endmodule

// File: rtl/adc_sport_shifter.sv
// Serial output register: loads the sample at frame open and sends it MSB first.
module adc_sport_shifter #(
  parameter int unsigned SAMPLE_W = 14,
  localparam int unsigned LW      = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic                frame_end_i,
  input  logic                launch_i,
  input  logic                armed_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sdo_o,
  output logic [LW-1:0]       bits_left_o
);

  logic [SAMPLE_W-1:0] word_q;
  logic [LW-1:0]       left_q;
  logic                sdo_q;
  logic                can_send;

  assign can_send = armed_i && (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
      sdo_q  <= 1'b0;
    end else if (frame_start_i) begin
      word_q <= sample_i;
      left_q <= LW'(SAMPLE_W);
      sdo_q  <= 1'b0;
    end else if (frame_end_i) begin
      sdo_q  <= 1'b0;
    end else if (launch_i) begin
      if (can_send) begin
        sdo_q  <= word_q[SAMPLE_W-1];
        word_q <= {word_q[SAMPLE_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        sdo_q  <= 1'b0;
      end
    end
  end

  assign sdo_o       = sdo_q;
  assign bits_left_o = left_q;

endmodule

// File: rtl/adc_sport_ctrl.sv
// Frame edge counter, mode state, invalid marking and calibration timer.
module adc_sport_ctrl
  import adc_sport_pkg::*;
#(
  parameter int unsigned ACQ_EDGES       = 18,
  parameter int unsigned PWRUP_CAL_EDGES = 24,
  parameter int unsigned NORM_CAL_EDGES  = 64,
  parameter int unsigned CAL_CYCLES      = 1000,
  localparam int unsigned CNT_W          = $clog2(NORM_CAL_EDGES + 1) + 1,
  localparam int unsigned TW             = $clog2(CAL_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sck_fall_i,
  output sport_state_e     state_o,
  output logic [CNT_W-1:0] falls_o,
  output logic             armed_o,
  output logic             pend_o,
  output logic             pwr_o,
  output logic             cal_exit_o,
  output logic             invalid_o,
  output logic             cal_done_o
);

  sport_state_e     st_q;
  logic [CNT_W-1:0] falls_q;
  logic [TW-1:0]    tmr_q;
  logic             pend_q;
  logic             inv_q;
  logic             pwr_q;
  logic             done_q;

  logic cal_enter_ev;
  logic acq_ev;
  logic cal_exit_ev;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign cal_enter_ev = cs_rise_i && (st_q != ST_CAL) &&
                        calib_match(pwr_q, 32'(falls_q), PWRUP_CAL_EDGES, NORM_CAL_EDGES);
  assign acq_ev       = sck_fall_i && (st_q != ST_CAL) &&
                        (falls_q == CNT_W'(ACQ_EDGES - 1));
  assign cal_exit_ev  = (st_q == ST_CAL) && (tmr_q == TW'(CAL_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      falls_q <= '0;
      pend_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      if (cs_fall_i) begin
        falls_q <= '0;
        inv_q   <= pend_q;
      end else if (sck_fall_i) begin
        falls_q <= bump(falls_q);
      end
      if (cs_rise_i) begin
        pend_q <= frame_short(32'(falls_q), ACQ_EDGES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      pwr_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (st_q == ST_CAL) begin
      if (cal_exit_ev) begin
        st_q   <= ST_ACQ;
        done_q <= 1'b1;
        pwr_q  <= 1'b0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end else if (cs_fall_i) begin
      st_q <= ST_SHIFT;
    end else if (cs_rise_i) begin
      if (cal_enter_ev) begin
        st_q   <= ST_CAL;
        tmr_q  <= '0;
        done_q <= 1'b0;
      end else if (st_q == ST_SHIFT) begin
        st_q <= ST_IDLE;
      end
    end else if (acq_ev) begin
      st_q <= ST_ACQ;
    end
  end

  assign state_o    = st_q;
  assign falls_o    = falls_q;
  assign armed_o    = falls_q != '0;
  assign pend_o     = pend_q;
  assign pwr_o      = pwr_q;
  assign cal_exit_o = cal_exit_ev;
  assign invalid_o  = inv_q;
  assign cal_done_o = done_q;

endmodule

// File: rtl/adc_sport_model.sv
// Device-side serial ADC port model.
module adc_sport_model
  import adc_sport_pkg::*;
#(
  parameter int unsigned SAMPLE_W        = 14,
  parameter int unsigned ACQ_EDGES       = 18,
  parameter int unsigned PWRUP_CAL_EDGES = 24,
  parameter int unsigned NORM_CAL_EDGES  = 64,
  parameter int unsigned CAL_CYCLES      = 1000,
  localparam int unsigned CNT_W          = $clog2(NORM_CAL_EDGES + 1) + 1,
  localparam int unsigned LW             = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                sclk_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sdo_o,
  output logic [1:0]          state_o,
  output logic                data_invalid_o,
  output logic                cal_done_o
);

  localparam int unsigned PIN_CS  = 0;
  localparam int unsigned PIN_SCK = 1;

  // Named internal events, also read by the bound checker.
  logic [1:0]       pin_lvl;
  logic [1:0]       pin_rise;
  logic [1:0]       pin_fall;
  logic             cs_fall_ev;
  logic             cs_rise_ev;
  logic             frame_open;
  logic             sck_fall_ev;
  logic             sck_rise_ev;
  logic [CNT_W-1:0] falls;
  logic             armed;
  logic             pend;
  logic             pwr;
  logic             cal_exit_ev;
  logic [LW-1:0]    bits_left;
  sport_state_e     st;

  adc_sport_edge #(
    .W        (2),
    .IDLE_LVL (2'b11)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({sclk_i, cs_n_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs_fall_ev  = pin_fall[PIN_CS];
  assign cs_rise_ev  = pin_rise[PIN_CS];
  assign frame_open  = ~pin_lvl[PIN_CS] & ~pin_fall[PIN_CS];
  assign sck_fall_ev = frame_open & pin_fall[PIN_SCK];
  assign sck_rise_ev = frame_open & pin_rise[PIN_SCK];

  adc_sport_ctrl #(
    .ACQ_EDGES       (ACQ_EDGES),
    .PWRUP_CAL_EDGES (PWRUP_CAL_EDGES),
    .NORM_CAL_EDGES  (NORM_CAL_EDGES),
    .CAL_CYCLES      (CAL_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall_i  (cs_fall_ev),
    .cs_rise_i  (cs_rise_ev),
    .sck_fall_i (sck_fall_ev),
    .state_o    (st),
    .falls_o    (falls),
    .armed_o    (armed),
    .pend_o     (pend),
    .pwr_o      (pwr),
    .cal_exit_o (cal_exit_ev),
    .invalid_o  (data_invalid_o),
    .cal_done_o (cal_done_o)
  );

  adc_sport_shifter #(
    .SAMPLE_W (SAMPLE_W)
  ) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (cs_fall_ev),
    .frame_end_i   (cs_rise_ev),
    .launch_i      (sck_rise_ev),
    .armed_i       (armed),
    .sample_i      (sample_i),
    .sdo_o         (sdo_o),
    .bits_left_o   (bits_left)
  );

  assign state_o = st;

endmodule

// File: rtl/adc_sport_model_chk.sv
module adc_sport_model_chk #(
  parameter int unsigned ACQ_EDGES = 18,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LW        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pin_lvl,
  input logic             cs_fall_ev,
  input logic             cs_rise_ev,
  input logic             sck_fall_ev,
  input logic             sck_rise_ev,
  input logic [CNT_W-1:0] falls,
  input logic             armed,
  input logic             pend,
  input logic             pwr,
  input logic             cal_exit_ev,
  input logic [LW-1:0]    bits_left,
  input logic [1:0]       state_o,
  input logic             sdo_o,
  input logic             data_invalid_o,
  input logic             cal_done_o
);

  assert_sdo_low_at_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_ev |=> !sdo_o);

  assert_sdo_low_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lvl[0] |=> !sdo_o);

  assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise_ev && bits_left == '0) |=> !sdo_o);

  assert_unarmed_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise_ev && !armed) |=> (!sdo_o && $stable(bits_left)));

  assert_acq_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall_ev && falls == CNT_W'(ACQ_EDGES - 1) && state_o != 2'd3) |=> state_o == 2'd2);

  assert_short_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_ev && falls < CNT_W'(ACQ_EDGES)) |=> pend);

  assert_invalid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_ev |=> (data_invalid_o == $past(pend)));

  assert_done_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done_o) |-> (state_o == 2'd2 && !pwr));

  assert_no_done_in_cal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd3 |-> !cal_done_o);

  assert_cal_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !cal_exit_ev) |=> state_o == 2'd3);

  assert_expiry_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cal_exit_ev |=> (state_o == 2'd2 && cal_done_o));

endmodule

bind adc_sport_model adc_sport_model_chk #(
  .ACQ_EDGES (ACQ_EDGES),
  .CNT_W     (CNT_W),
  .LW        (LW)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_lvl        (pin_lvl),
  .cs_fall_ev     (cs_fall_ev),
  .cs_rise_ev     (cs_rise_ev),
  .sck_fall_ev    (sck_fall_ev),
  .sck_rise_ev    (sck_rise_ev),
  .falls          (falls),
  .armed          (armed),
  .pend           (pend),
  .pwr            (pwr),
  .cal_exit_ev    (cal_exit_ev),
  .bits_left      (bits_left),
  .state_o        (state_o),
  .sdo_o          (sdo_o),
  .data_invalid_o (data_invalid_o),
  .cal_done_o     (cal_done_o)
);

// File: tb/adc_sport_model_tb.sv
`timescale 1ns/1ps
module adc_sport_model_tb_top;

  localparam int SW   = 14;
  localparam int ACQ  = 18;
  localparam int PWN  = 24;
  localparam int NMN  = 64;
  localparam int CALN = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b1;
  logic [SW-1:0] sample = '0;
  logic          sdo;
  logic [1:0]    state;
  logic          inv;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int cal_enter_cyc = -1;
  logic [1:0] prev_state = 2'd0;
  bit   finished = 0;

  always #5 clk = ~clk;

  adc_sport_model #(
    .SAMPLE_W        (SW),
    .ACQ_EDGES       (ACQ),
    .PWRUP_CAL_EDGES (PWN),
    .NORM_CAL_EDGES  (NMN),
    .CAL_CYCLES      (CALN)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_n_i         (cs_n),
    .sclk_i         (sclk),
    .sample_i       (sample),
    .sdo_o          (sdo),
    .state_o        (state),
    .data_invalid_o (inv),
    .cal_done_o     (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit q_cs[$];
  bit q_sk[$];
  bit m_bits[$];
  int m_state, m_falls, m_tmr;
  bit m_sdo, m_pend, m_inv, m_pwr, m_done;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_cs = '{1'b1, 1'b1};
      q_sk = '{1'b1, 1'b1};
      m_bits.delete();
      m_state = 0; m_falls = 0; m_tmr = 0;
      m_sdo = 0; m_pend = 0; m_inv = 0; m_pwr = 1; m_done = 0;
    end else begin
      bit o_cs, n_cs, o_sk, n_sk, csf, csr, open_f, sf, sr;
      int was;
      o_cs = q_cs[0]; n_cs = q_cs[1];
      o_sk = q_sk[0]; n_sk = q_sk[1];
      csf = o_cs && !n_cs;
      csr = !o_cs && n_cs;
      open_f = !o_cs && !n_cs;
      sf = open_f && o_sk && !n_sk;
      sr = open_f && !o_sk && n_sk;
      was = m_state;
      if (was == 3) begin
        m_tmr++;
        if (m_tmr == CALN) begin m_state = 2; m_done = 1; m_pwr = 0; end
      end
      if (csf) begin
        m_falls = 0;
        m_bits.delete();
        for (int i = SW - 1; i >= 0; i--) m_bits.push_back(sample[i]);
        m_inv = m_pend;
        m_sdo = 0;
        if (was != 3) m_state = 1;
      end else if (csr) begin
        m_sdo = 0;
        if (was != 3) begin
          if ((m_pwr && m_falls == PWN) || (!m_pwr && m_falls == NMN)) begin
            m_state = 3; m_tmr = 0; m_done = 0;
          end else if (was == 1) m_state = 0;
        end
        m_pend = (m_falls < ACQ);
      end else if (sf) begin
        if (m_falls < 255) m_falls++;
        if (m_falls == ACQ && was != 3) m_state = 2;
      end else if (sr) begin
        if (m_falls > 0 && m_bits.size() > 0) m_sdo = m_bits.pop_front();
        else m_sdo = 0;
      end
      void'(q_cs.pop_front());
      void'(q_sk.pop_front());
      q_cs.push_back(cs_n);
      q_sk.push_back(sclk);
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 sdo vs model", int'(sdo), int'(m_sdo));
      chk("R6 state vs model", int'(state), m_state);
      chk("R7 invalid vs model", int'(inv), int'(m_inv));
      chk("R10 cal_done vs model", int'(done), int'(m_done));
      if (state == 2'd3 && prev_state != 2'd3) cal_enter_cyc = cyc;
      prev_state = state;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [SW-1:0] s,
                       output logic [SW-1:0] w, output bit tail_ok);
    w = '0;
    tail_ok = 1;
    sample = s;
    cs_n = 1'b0;
    ticks(3);
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b0;
      ticks(2);
      sclk = 1'b1;
      ticks(2);
      if (k <= SW) w = {w[SW-2:0], sdo};
      else if (sdo) tail_ok = 0;
    end
    cs_n = 1'b1;
    ticks(4);
  endtask

  logic [SW-1:0] word;
  bit            tail;

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    // R1 reset state
    chk("R1 state", int'(state), 0);
    chk("R1 sdo", int'(sdo), 0);
    chk("R1 invalid", int'(inv), 0);
    chk("R1 cal_done", int'(done), 0);

    // R3/R4: 20-edge frame, word MSB first then zeros
    frame(20, 14'h2A5C, word, tail);
    chk("R3 word", int'(word), 'h2A5C);
    chk("R4 tail zeros", int'(tail), 1);
    chk("R6 acq after 20 edges", int'(state), 2);
    chk("R2 sdo low while deselected", int'(sdo), 0);

    // R7 short frame marks the next one invalid; state drops to idle
    frame(10, 14'h1111, word, tail);
    chk("R6 short frame leaves idle", int'(state), 0);

    // R12 latency on chip select
    cs_n = 1'b0;
    ticks(1);
    chk("R12 no change after one clock", int'(state), 0);
    ticks(1);
    chk("R12 frame state after two clocks", int'(state), 1);
    chk("R7 invalid in frame after short", int'(inv), 1);
    cs_n = 1'b1;
    ticks(4);

    frame(18, 14'h3FFF, word, tail);
    chk("R3 all-ones word", int'(word), 'h3FFF);
    chk("R7 invalid held after frame", int'(inv), 1);
    chk("R6 exactly 18 edges", int'(state), 2);
    frame(19, 14'h0001, word, tail);
    chk("R7 invalid cleared", int'(inv), 0);
    chk("R3 lsb-only word", int'(word), 'h0001);

    // R8: 64 edges at power-up do not calibrate, 24 do
    frame(64, 14'h0F0F, word, tail);
    chk("R8 64 at power-up no cal", int'(state), 2);
    chk("R4 long tail zeros", int'(tail), 1);
    frame(24, 14'h0ABC, word, tail);
    chk("R8 24 at power-up enters cal", int'(state), 3);
    chk("R10 done low in cal", int'(done), 0);

    // R11: a 24-edge frame inside calibration changes nothing
    frame(24, 14'h1234, word, tail);
    chk("R11 still calibrating", int'(state), 3);
    chk("R3 data during cal", int'(word), 'h1234);

    // R10 exact length
    while (cyc < cal_enter_cyc + CALN - 1) ticks(1);
    chk("R10 last cal cycle", int'(state), 3);
    ticks(1);
    chk("R10 cal exit to acq", int'(state), 2);
    chk("R10 done raised", int'(done), 1);

    // R9: after power-up, 24 no longer calibrates, 64 does
    frame(24, 14'h0555, word, tail);
    chk("R9 24 after power-up no cal", int'(state), 2);
    frame(64, 14'h2222, word, tail);
    chk("R9 64 enters cal", int'(state), 3);

    // R11 coincidence: 64-edge frame closing on the expiry cycle
    sample = 14'h3333;
    cs_n = 1'b0;
    ticks(3);
    for (int k = 1; k <= NMN; k++) begin
      sclk = 1'b0; ticks(2);
      sclk = 1'b1; ticks(2);
    end
    while (cyc < cal_enter_cyc + CALN - 2) ticks(1);
    cs_n = 1'b1;
    ticks(2);
    chk("R11 expiry wins over frame end", int'(state), 2);
    chk("R11 done after coincidence", int'(done), 1);
    ticks(4);
    chk("R11 no recalibration", int'(state), 2);

    // R5: rising edge before any falling edge sends nothing
    sclk = 1'b0;
    ticks(2);
    sample = 14'h2001;
    cs_n = 1'b0;
    ticks(3);
    sclk = 1'b1;
    ticks(2);
    chk("R5 early rise gives zero", int'(sdo), 0);
    word = '0;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0; ticks(2);
      sclk = 1'b1; ticks(2);
      if (k <= SW) word = {word[SW-2:0], sdo};
    end
    chk("R5 no bit consumed", int'(word), 'h2001);
    cs_n = 1'b1;
    ticks(3);
    chk("R2 sdo low after close", int'(sdo), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule